// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a pixel-clocked display link. Each axis steps through four phases: a sync pulse, a back porch, the visible region and a front porch. The horizontal axis moves one phase count per clock. The vertical axis moves one count each time a full line completes. The length of every phase comes from its own register. From the phase state the block drives hsync, vsync, data-enable, the pixel word and the x/y position of the current visible pixel. Every output passes through a programmable polarity.

Pixels enter through a request/valid pair. The block asserts `pix_req` while it is in the visible region. If the source has no valid word at that moment, the block blanks the pixel and records an underrun. A small interrupt unit holds two raw event bits: a frame-start event on the first clock of vertical sync, and the underrun. Each bit is gated by a mask. Software acknowledges events by writing ones back to a clear register. The whole raster runs only while the enable bit is set. Timing registers can be changed only while the raster is stopped.

Top module: `disp_timing_gen`

## Requirements
- R1: Each axis runs its phases in the order sync, back porch, visible, front porch, then returns to sync. The horizontal axis advances every clock. The vertical axis advances once per completed line.
- R2: A phase register holding N gives a phase N+1 clocks long (horizontal) or N+1 lines long (vertical). Register addresses are {1,axis,phase}: axis 0 is horizontal and axis 1 is vertical. The phase codes are sync=0, back=1, visible=2, front=3.
- R3: `de_o` is asserted only when both axes are in their visible phase. In that case `x_o` and `y_o` give the zero-based position inside the visible area. Otherwise `x_o` and `y_o` are 0.
- R4: Polarity register (address 1) bit 0 controls hsync, bit 1 controls vsync and bit 2 controls data-enable. A set bit makes that output active-high and a clear bit makes it active-low. The reset value of the polarity register is 0x0F.
- R5: Polarity bit 3 set passes pixel data unchanged, and clear inverts every bit of it. Pixels outside the visible region, and underrun pixels, are zero before inversion. Polarity bit 4 is driven to `clk_inv_o`.
- R6: Control register (address 0) bit 0 enables the raster. While it is clear, both axes are held at the first clock of sync and every output sits at its inactive level. Outputs reflect the counter state of the previous clock.
- R7: A write to any timing register is ignored while the raster is enabled.
- R8: Raw status (address 3) bit 0 is set on the first clock of vertical sync (which coincides with the first clock of horizontal sync). Bit 1 is set when a visible pixel is requested while `pix_valid` is low.
- R9: `irq_o` is high whenever any raw status bit is set and its mask bit (mask register, address 2, same bit positions) is also set.
- R10: Writing to the clear register (address 4) clears exactly the raw status bits written as ones and leaves the others unchanged.
- R11: A register placed on `reg_raddr` appears on `reg_rdata` after the next rising edge. Control, polarity and timing registers read back what was written. Timing registers are wide enough for values such as 1679 and 1049.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | 32 | Registered read data |
| pix_in | input | PIX_W | Incoming pixel word |
| pix_valid | input | 1 | Pixel word is valid |
| pix_req | output | 1 | A visible pixel is consumed this clock |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pix_o | output | PIX_W | Pixel data after blanking and polarity |
| x_o | output | H_W | Visible column |
| y_o | output | V_W | Visible row |
| clk_inv_o | output | 1 | Pixel clock inversion select |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Sync, enable, pixel and coordinate outputs show the counter state one clock after that state exists. A raw status bit is set on the same edge as the output that shows its event, and `irq_o` follows the status and mask registers with no further delay. A register read is valid one edge after the address is presented. The bench models the raster by position counts and tracks the register writes it issues, predicting each output for the edge it is due. It compares all outputs at the falling edge, half a period after the edge that produced them. Register readbacks are sampled one full clock after the address is driven.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BACK   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_FRONT  = 2'd3
  } phase_e;

  localparam int ADDR_W   = 4;
  localparam int NUM_EVT  = 2;
  localparam int POL_W    = 5;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_POL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd2;
  localparam logic [ADDR_W-1:0] A_RAW   = 4'd3;
  localparam logic [ADDR_W-1:0] A_CLEAR = 4'd4;
  localparam logic [POL_W-1:0]  POL_RST = 5'b01111;
endpackage

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  step,
  input  logic [3:0][CNT_W-1:0] len,
  output phase_e                phase,
  output logic [CNT_W-1:0]      cnt,
  output logic                  wrap
);
  logic       last;
  logic [1:0] nxt_ph;

  assign last   = (cnt == len[phase]);
  assign nxt_ph = phase + 2'd1;
  assign wrap   = step && last && (phase == PH_FRONT);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (step) begin
      if (last) begin
        cnt   <= '0;
        phase <= phase_e'(nxt_ph);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (run && $stable(len)) |-> (cnt <= len[phase]));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase == PH_SYNC && cnt == '0));

  p_order_r1: assert property (@(posedge clk) disable iff (rst)
    (run && step && last && phase == PH_BACK) |=> (!run || phase == PH_ACTIVE));
endmodule

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int H_W   = 12,
  parameter int V_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [REG_W-1:0]     wdata,
  input  logic [ADDR_W-1:0]    raddr,
  input  logic [NUM_EVT-1:0]   raw_status,
  output logic                 enable,
  output logic [POL_W-1:0]     pol,
  output logic [NUM_EVT-1:0]   mask,
  output logic                 clr_valid,
  output logic [NUM_EVT-1:0]   clr_bits,
  output logic [3:0][H_W-1:0]  hlen,
  output logic [3:0][V_W-1:0]  vlen,
  output logic [REG_W-1:0]     rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      pol    <= POL_RST;
      mask   <= '0;
    end else if (we) begin
      if (waddr == A_CTRL) enable <= wdata[0];
      if (waddr == A_POL)  pol    <= wdata[POL_W-1:0];
      if (waddr == A_MASK) mask   <= wdata[NUM_EVT-1:0];
    end
  end

  assign clr_valid = we && (waddr == A_CLEAR);
  assign clr_bits  = wdata[NUM_EVT-1:0];

  for (genvar g = 0; g < 4; g++) begin : g_len
    always_ff @(posedge clk) begin
      if (rst) begin
        hlen[g] <= '0;
        vlen[g] <= '0;
      end else if (we && !enable) begin
        if (waddr == ADDR_W'(8 + g))  hlen[g] <= wdata[H_W-1:0];
        if (waddr == ADDR_W'(12 + g)) vlen[g] <= wdata[V_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (raddr[3]) begin
      rdata <= raddr[2] ? REG_W'(vlen[raddr[1:0]]) : REG_W'(hlen[raddr[1:0]]);
    end else begin
      case (raddr)
        A_CTRL:  rdata <= REG_W'(enable);
        A_POL:   rdata <= REG_W'(pol);
        A_MASK:  rdata <= REG_W'(mask);
        A_RAW:   rdata <= REG_W'(raw_status);
        default: rdata <= '0;
      endcase
    end
  end

  p_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (we && enable && waddr[3]) |=> ($stable(hlen) && $stable(vlen)));
endmodule

// File: rtl/dtg_irq.sv
module dtg_irq
  import dtg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] set_evt,
  input  logic               clr_valid,
  input  logic [NUM_EVT-1:0] clr_bits,
  input  logic [NUM_EVT-1:0] mask,
  output logic [NUM_EVT-1:0] raw,
  output logic               irq
);
  logic [NUM_EVT-1:0] clr_eff;

  assign clr_eff = clr_valid ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) raw <= '0;
    else     raw <= (raw & ~clr_eff) | set_evt;
  end

  assign irq = |(raw & mask);

  p_set_r8: assert property (@(posedge clk) disable iff (rst)
    set_evt[0] |=> raw[0]);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && clr_bits[1] && !set_evt[1]) |=> !raw[1]);

  p_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (raw[0] && !(clr_valid && clr_bits[0])) |=> raw[0]);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int H_W   = 12,
  parameter int V_W   = 12,
  parameter int PIX_W = 24,
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_waddr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [3:0]        reg_raddr,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              pix_valid,
  output logic              pix_req,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic [H_W-1:0]    x_o,
  output logic [V_W-1:0]    y_o,
  output logic              clk_inv_o,
  output logic              irq_o
);
  logic                enable;
  logic [POL_W-1:0]    pol;
  logic [NUM_EVT-1:0]  mask, raw, clr_bits, set_evt;
  logic                clr_valid;
  logic [3:0][H_W-1:0] hlen;
  logic [3:0][V_W-1:0] vlen;
  phase_e              h_ph, v_ph;
  logic [H_W-1:0]      h_cnt;
  logic [V_W-1:0]      v_cnt;
  logic                h_wrap, v_wrap;
  logic                hs_act, vs_act, frame_start;

  dtg_regs #(.REG_W(REG_W), .H_W(H_W), .V_W(V_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .raw_status(raw), .enable(enable), .pol(pol),
    .mask(mask), .clr_valid(clr_valid), .clr_bits(clr_bits),
    .hlen(hlen), .vlen(vlen), .rdata(reg_rdata)
  );

  dtg_axis #(.CNT_W(H_W)) u_haxis (
    .clk(clk), .rst(rst), .run(enable), .step(1'b1), .len(hlen),
    .phase(h_ph), .cnt(h_cnt), .wrap(h_wrap)
  );

  dtg_axis #(.CNT_W(V_W)) u_vaxis (
    .clk(clk), .rst(rst), .run(enable), .step(h_wrap), .len(vlen),
    .phase(v_ph), .cnt(v_cnt), .wrap(v_wrap)
  );

  assign pix_req     = enable && (h_ph == PH_ACTIVE) && (v_ph == PH_ACTIVE);
  assign hs_act      = enable && (h_ph == PH_SYNC);
  assign vs_act      = enable && (v_ph == PH_SYNC);
  assign frame_start = hs_act && vs_act && (h_cnt == '0) && (v_cnt == '0);
  assign set_evt     = {pix_req && !pix_valid, frame_start};

  dtg_irq u_irq (
    .clk(clk), .rst(rst), .set_evt(set_evt), .clr_valid(clr_valid),
    .clr_bits(clr_bits), .mask(mask), .raw(raw), .irq(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o   <= 1'b0;
      vsync_o   <= 1'b0;
      de_o      <= 1'b0;
      pix_o     <= '0;
      x_o       <= '0;
      y_o       <= '0;
      clk_inv_o <= 1'b0;
    end else begin
      hsync_o   <= ~(hs_act ^ pol[0]);
      vsync_o   <= ~(vs_act ^ pol[1]);
      de_o      <= ~(pix_req ^ pol[2]);
      pix_o     <= ((pix_req && pix_valid) ? pix_in : '0) ^ {PIX_W{~pol[3]}};
      x_o       <= pix_req ? h_cnt : '0;
      y_o       <= pix_req ? v_cnt : '0;
      clk_inv_o <= pol[4];
    end
  end

  p_off_r6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (hsync_o == !$past(pol[0]) && vsync_o == !$past(pol[1])
                 && de_o == !$past(pol[2])));

  p_xy_r3: assert property (@(posedge clk) disable iff (rst)
    !pix_req |=> (x_o == '0 && y_o == '0));

  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (enable && v_wrap) |=> (!enable || v_ph == PH_SYNC));
endmodule

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;
  localparam int H_W = 12, V_W = 12, PIX_W = 24, REG_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [3:0] reg_waddr = '0, reg_raddr = '0;
  logic [REG_W-1:0] reg_wdata = '0, reg_rdata;
  logic [PIX_W-1:0] pix_in = '0, pix_o;
  logic pix_valid = 1'b0, pix_req;
  logic hsync_o, vsync_o, de_o, clk_inv_o, irq_o;
  logic [H_W-1:0] x_o;
  logic [V_W-1:0] y_o;

  always #2.5 clk = ~clk;

  disp_timing_gen #(.H_W(H_W), .V_W(V_W), .PIX_W(PIX_W), .REG_W(REG_W)) u_disp_timing_gen (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .pix_in(pix_in), .pix_valid(pix_valid), .pix_req(pix_req),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_o(pix_o),
    .x_o(x_o), .y_o(y_o), .clk_inv_o(clk_inv_o), .irq_o(irq_o)
  );

  int checks = 0, failures = 0;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  hl[4], vl[4];
  int  m_hp, m_vp;
  bit  m_en;
  bit  [4:0] m_pol;
  bit  [1:0] m_mask, m_raw;
  bit  e_hs, e_vs, e_de, e_ci;
  bit  [PIX_W-1:0] e_pix;
  int  e_x, e_y;

  task automatic locate(input int p, input bit vert, output int ph, output int off);
    int acc = 0;
    ph = 3; off = 0;
    for (int k = 0; k < 4; k++) begin
      int len = vert ? vl[k] + 1 : hl[k] + 1;
      if (p < acc + len) begin ph = k; off = p - acc; return; end
      acc += len;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_pol = 5'b01111; m_mask = 0; m_raw = 0;
      m_hp = 0; m_vp = 0;
      for (int k = 0; k < 4; k++) begin hl[k] = 0; vl[k] = 0; end
      e_hs = 0; e_vs = 0; e_de = 0; e_ci = 0; e_pix = 0; e_x = 0; e_y = 0;
    end else begin
      int hph, hoff, vph, voff, htot, vtot;
      bit act;
      locate(m_hp, 0, hph, hoff);
      locate(m_vp, 1, vph, voff);
      act   = m_en && hph == 2 && vph == 2;
      e_hs  = ((m_en && hph == 0) == m_pol[0]);
      e_vs  = ((m_en && vph == 0) == m_pol[1]);
      e_de  = (act == m_pol[2]);
      e_pix = (act && pix_valid) ? pix_in : '0;
      if (!m_pol[3]) e_pix = ~e_pix;
      e_x   = act ? hoff : 0;
      e_y   = act ? voff : 0;
      e_ci  = m_pol[4];
      if (reg_we && reg_waddr == 4) m_raw &= ~reg_wdata[1:0];
      if (m_en && m_hp == 0 && m_vp == 0) m_raw[0] = 1;
      if (act && !pix_valid) m_raw[1] = 1;
      htot = 0; vtot = 0;
      for (int k = 0; k < 4; k++) begin htot += hl[k] + 1; vtot += vl[k] + 1; end
      if (!m_en) begin m_hp = 0; m_vp = 0; end
      else begin
        m_hp++;
        if (m_hp == htot) begin
          m_hp = 0; m_vp++;
          if (m_vp == vtot) m_vp = 0;
        end
      end
      if (reg_we) begin
        case (reg_waddr)
          4'd0: m_en = reg_wdata[0];
          4'd1: m_pol = reg_wdata[4:0];
          4'd2: m_mask = reg_wdata[1:0];
          default: begin
            if (reg_waddr >= 8 && !m_en) begin
              if (reg_waddr < 12) hl[reg_waddr - 8] = int'(reg_wdata[H_W-1:0]);
              else vl[reg_waddr - 12] = int'(reg_wdata[V_W-1:0]);
            end
          end
        endcase
      end
    end
  end

  // per-clock comparison, half a period after the producing edge
  bit cmp_on = 0;
  int hs_run = 0, hs_last = 0, vs_run = 0, vs_last = 0;
  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      check("R1/R4 hsync", hsync_o, e_hs);
      check("R1/R4 vsync", vsync_o, e_vs);
      check("R3/R4 de", de_o, e_de);
      check("R3 x", x_o, e_x);
      check("R3 y", y_o, e_y);
      check("R5 pixel", pix_o, e_pix);
      check("R5 clk_inv", clk_inv_o, e_ci);
      check("R9 irq", irq_o, |(m_raw & m_mask));
    end
    if (hsync_o) hs_run++; else if (hs_run > 0) begin hs_last = hs_run; hs_run = 0; end
    if (vsync_o) vs_run++; else if (vs_run > 0) begin vs_last = vs_run; vs_run = 0; end
  end

  // pixel source with a periodic gap
  int pcnt = 0;
  always @(negedge clk) begin
    pcnt++;
    pix_in    <= PIX_W'(pcnt * 37);
    pix_valid <= (pcnt % 13) != 5;
  end

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    reg_we = 1; reg_waddr = a; reg_wdata = REG_W'(d);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk);
    reg_raddr = a;
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int d;
    repeat (4) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    // R11 reset readback
    rd(4'd0, d); check("R11 ctrl reset", d, 0);
    rd(4'd1, d); check("R11/R4 polarity reset", d, 15);
    // small mode: h 3/2/4/2, v 2/1/3/1
    wr(4'd8, 2); wr(4'd9, 1); wr(4'd10, 3); wr(4'd11, 1);
    wr(4'd12, 1); wr(4'd13, 0); wr(4'd14, 2); wr(4'd15, 0);
    rd(4'd10, d); check("R11 h visible readback", d, 3);
    wr(4'd2, 1);
    wr(4'd0, 1);
    idle(200);
    check("R2 hsync width", hs_last, 3);
    check("R2 vsync width", vs_last, 22);
    // R7 timing write while enabled
    wr(4'd10, 9);
    rd(4'd10, d); check("R7 locked h visible", d, 3);
    idle(80);
    wr(4'd2, 3);
    idle(40);
    // stop, then status handling
    wr(4'd0, 0);
    idle(5);
    check("R6 hsync idle", hsync_o, 0);
    check("R6 de idle", de_o, 0);
    rd(4'd3, d); check("R8 raw both events", d, 3);
    wr(4'd4, 2);
    rd(4'd3, d); check("R10 partial clear", d, 1);
    check("R9 irq after partial clear", irq_o, 1);
    wr(4'd4, 1);
    rd(4'd3, d); check("R10 full clear", d, 0);
    check("R9 irq cleared", irq_o, 0);
    // inverted polarities and clock inversion
    wr(4'd1, 16);
    idle(3);
    check("R6/R4 active-low idle hsync", hsync_o, 1);
    check("R5 inverted idle pixel", pix_o, (1 << PIX_W) - 1);
    wr(4'd0, 1);
    idle(160);
    wr(4'd0, 0);
    idle(4);
    // large mode values
    wr(4'd10, 1679); wr(4'd14, 1049);
    rd(4'd10, d); check("R11 h visible 1679", d, 1679);
    rd(4'd14, d); check("R11 v visible 1049", d, 1049);
    rd(4'd1, d); check("R11 polarity readback", d, 16);
    idle(4);
    finish_run();
  end
endmodule